// File: doc/BRIEF.md
# Two's-Complement Adder/Subtracter with Overflow Flags

This block adds or subtracts two N-bit operands (8 bits by default) and reports the outcome both as a wrapped N-bit word and as an exact (N+1)-bit two's-complement value. A single select line chooses between addition and subtraction. Subtraction inverts the second operand and feeds a carry-in of one into the same adder that addition uses. The adder is a plain unsigned adder with a carry-out. The block never looks inside it.

Two flags accompany the result. The signed-overflow flag is derived only from the sign bits of the two effective addends and of the N-bit sum. The unsigned-overflow flag is the adder carry-out when adding, and the inverted carry-out (a borrow) when subtracting. The exact result comes from a second, one-bit-wider sum of the sign-extended effective addends, so it is never wrapped.

A parameter picks between purely combinational outputs and a single output register stage for timing closure. The register has an active-low asynchronous reset.

Top module: `addsub_flags`

## Requirements
- R1: With sub_sel = 0, sum_o equals (op_a + op_b) modulo 2^N.
- R2: With sub_sel = 1, sum_o equals (op_a + ~op_b + 1) modulo 2^N, which is op_a − op_b modulo 2^N.
- R3: sovf_o is 1 exactly when the effective addends (op_a and, when subtracting, ~op_b) share a sign bit and bit N−1 of sum_o differs from it. This always equals the carry into bit N−1 XOR the carry out of bit N−1.
- R4: exact_o is the true signed value of op_a + op_b (or op_a − op_b), as an (N+1)-bit two's-complement word. For example, 0x03 + 0xFE at N = 8 gives 9'h001.
- R5: uovf_o is the adder carry-out when adding. When subtracting it is 1 exactly when op_a < op_b as unsigned numbers.
- R6: Subtracting the most negative value (only bit N−1 set) raises sovf_o exactly when op_a is non-negative. exact_o then holds op_a + 2^(N−1).
- R7: At N = 3: 110 + 011 gives 001 with no signed overflow, and 001 − 011 gives 110 with no signed overflow. At N = 4: 1101 − 1010 gives 0011 with no signed overflow.
- R8: With REG_OUT = 1, every output shows the result of the inputs present at the previous rising clk edge. While rst_n is 0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| op_a | input | N | First operand |
| op_b | input | N | Second operand |
| sub_sel | input | 1 | 0 selects addition, 1 selects subtraction |
| sum_o | output | N | Wrapped N-bit result |
| exact_o | output | N+1 | Exact sign-extended result |
| sovf_o | output | 1 | Signed overflow of the N-bit result |
| uovf_o | output | 1 | Unsigned carry (add) or borrow (subtract) |

## Verification
The bench builds four instances: combinational ones at N = 8, N = 4 and N = 3, and a registered one at N = 4.

At N = 8 and N = 4 it drives every operand pair in both modes against integer arithmetic. It also recomputes signed overflow from the carries into and out of the top bit, so the sign-bit method and the carry method are compared on every input. The N = 3 and N = 4 instances make the small hand-worked cases reachable. The registered instance exposes the one-cycle latency and the reset values.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } addsub_op_e;
endpackage

// File: rtl/addsub_operand.sv
module addsub_operand
    import addsub_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] op_b,
    input  logic         sub_sel,
    output logic [N-1:0] b_eff,
    output logic         carry_in
);
    addsub_op_e op;

    always_comb begin
        op = addsub_op_e'(sub_sel);
        unique case (op)
            OP_SUB: begin
                b_eff    = ~op_b;
                carry_in = 1'b1;
            end
            default: begin
                b_eff    = op_b;
                carry_in = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/addsub_uadder.sv
module addsub_uadder #(
    parameter int N = 8
) (
    input  logic [N-1:0] in_x,
    input  logic [N-1:0] in_y,
    input  logic         cin,
    output logic [N-1:0] sum,
    output logic         cout
);
    localparam int W = N + 1;

    logic [W-1:0] wide;

    always_comb begin
        wide = {1'b0, in_x} + {1'b0, in_y} + {{N{1'b0}}, cin};
        sum  = wide[N-1:0];
        cout = wide[N];
    end
endmodule

// File: rtl/addsub_sign_ovf.sv
module addsub_sign_ovf (
    input  logic x_msb,
    input  logic y_msb,
    input  logic s_msb,
    output logic ovf
);
    // Operands agree in sign, result disagrees.
    always_comb ovf = (x_msb ~^ y_msb) & (s_msb ^ x_msb);
endmodule

// File: rtl/addsub_exact.sv
module addsub_exact #(
    parameter int N = 8
) (
    input  logic [N-1:0] in_x,
    input  logic [N-1:0] in_y,
    input  logic         cin,
    output logic [N:0]   exact
);
    localparam int MSB = N - 1;

    logic [N:0] x_ext;
    logic [N:0] y_ext;

    always_comb begin
        x_ext = {in_x[MSB], in_x};
        y_ext = {in_y[MSB], in_y};
        exact = x_ext + y_ext + {{N{1'b0}}, cin};
    end
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
    import addsub_pkg::*;
#(
    parameter int N       = 8,
    parameter bit REG_OUT = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic         sub_sel,
    output logic [N-1:0] sum_o,
    output logic [N:0]   exact_o,
    output logic         sovf_o,
    output logic         uovf_o
);
    localparam int MSB = N - 1;

    logic [N-1:0] b_eff;
    logic         cin;
    logic [N-1:0] sum_w;
    logic         cout_w;
    logic         sovf_w;
    logic         uovf_w;
    logic [N:0]   exact_w;

    addsub_operand #(.N(N)) u_operand (
        .op_b     (op_b),
        .sub_sel  (sub_sel),
        .b_eff    (b_eff),
        .carry_in (cin)
    );

    addsub_uadder #(.N(N)) u_adder (
        .in_x (op_a),
        .in_y (b_eff),
        .cin  (cin),
        .sum  (sum_w),
        .cout (cout_w)
    );

    addsub_sign_ovf u_sovf (
        .x_msb (op_a[MSB]),
        .y_msb (b_eff[MSB]),
        .s_msb (sum_w[MSB]),
        .ovf   (sovf_w)
    );

    addsub_exact #(.N(N)) u_exact (
        .in_x  (op_a),
        .in_y  (b_eff),
        .cin   (cin),
        .exact (exact_w)
    );

    always_comb uovf_w = cout_w ^ sub_sel;

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sum_o   <= '0;
                    exact_o <= '0;
                    sovf_o  <= 1'b0;
                    uovf_o  <= 1'b0;
                end else begin
                    sum_o   <= sum_w;
                    exact_o <= exact_w;
                    sovf_o  <= sovf_w;
                    uovf_o  <= uovf_w;
                end
            end

            // R8: outputs follow the previous edge's inputs.
            a_r8_reg_follow: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (sum_o == $past(sum_w)) && (exact_o == $past(exact_w))
                         && (sovf_o == $past(sovf_w)) && (uovf_o == $past(uovf_w)));
            // R8: reset clears the outputs.
            a_r8_reset_zero: assert property (@(posedge clk)
                !rst_n |=> (exact_o == '0) && !sovf_o && !uovf_o);
        end else begin : g_comb
            always_comb begin
                sum_o   = sum_w;
                exact_o = exact_w;
                sovf_o  = sovf_w;
                uovf_o  = uovf_w;
            end
        end
    endgenerate

    // R3: sign method agrees with the carry-in/carry-out method.
    a_r3_carry_agree: assert property (@(posedge clk) disable iff (!rst_n)
        sovf_w == (cout_w ^ (op_a[MSB] ^ b_eff[MSB] ^ sum_w[MSB])));
    // R3: overflow exactly when the exact result's top two bits differ.
    a_r3_exact_sign: assert property (@(posedge clk) disable iff (!rst_n)
        sovf_w == (exact_w[N] ^ exact_w[MSB]));
    // R4: the low bits of the wide sum match the wrapped sum.
    a_r4_exact_low: assert property (@(posedge clk) disable iff (!rst_n)
        exact_w[MSB:0] == sum_w);
    // R5: borrow flag during subtraction.
    a_r5_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        sub_sel |-> (uovf_w == (op_a < op_b)));
endmodule

// File: tb/addsub_flags_bench.sv
module addsub_flags_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    // N = 8 combinational
    logic [7:0] a8, b8, s8;
    logic       sub8, so8, uo8;
    logic [8:0] x8;
    addsub_flags #(.N(8), .REG_OUT(1'b0)) u_addsub_flags (
        .clk(clk), .rst_n(rst_n), .op_a(a8), .op_b(b8), .sub_sel(sub8),
        .sum_o(s8), .exact_o(x8), .sovf_o(so8), .uovf_o(uo8));

    // N = 4 combinational
    logic [3:0] a4, b4, s4;
    logic       sub4, so4, uo4;
    logic [4:0] x4;
    addsub_flags #(.N(4), .REG_OUT(1'b0)) u_w4 (
        .clk(clk), .rst_n(rst_n), .op_a(a4), .op_b(b4), .sub_sel(sub4),
        .sum_o(s4), .exact_o(x4), .sovf_o(so4), .uovf_o(uo4));

    // N = 3 combinational
    logic [2:0] a3, b3, s3;
    logic       sub3, so3, uo3;
    logic [3:0] x3;
    addsub_flags #(.N(3), .REG_OUT(1'b0)) u_w3 (
        .clk(clk), .rst_n(rst_n), .op_a(a3), .op_b(b3), .sub_sel(sub3),
        .sum_o(s3), .exact_o(x3), .sovf_o(so3), .uovf_o(uo3));

    // N = 4 registered
    logic [3:0] ra, rb, rs;
    logic       rsub, rso, ruo;
    logic [4:0] rx;
    addsub_flags #(.N(4), .REG_OUT(1'b1)) u_r4 (
        .clk(clk), .rst_n(rst_n), .op_a(ra), .op_b(rb), .sub_sel(rsub),
        .sum_o(rs), .exact_o(rx), .sovf_o(rso), .uovf_o(ruo));

    // {a[8], b[8], sub, exact[9], sovf, uovf}
    localparam logic [27:0] VEC [8] = '{
        {8'h03, 8'hFE, 1'b0, 9'h001, 1'b0, 1'b1},  // R4: 3 + (-2) = +1
        {8'h7F, 8'h01, 1'b0, 9'h080, 1'b1, 1'b0},  // R3: pos + pos = neg
        {8'h80, 8'h80, 1'b0, 9'h100, 1'b1, 1'b1},  // R3: neg + neg = pos
        {8'h05, 8'h80, 1'b1, 9'h085, 1'b1, 1'b1},  // R6: 5 - (-128)
        {8'hFF, 8'h80, 1'b1, 9'h07F, 1'b0, 1'b0},  // R6: -1 - (-128)
        {8'h00, 8'h00, 1'b1, 9'h000, 1'b0, 1'b0},  // R2: zero minus zero
        {8'h80, 8'h01, 1'b1, 9'h17F, 1'b1, 1'b0},  // R3: -128 - 1
        {8'h00, 8'h01, 1'b1, 9'h1FF, 1'b0, 1'b1}   // R5: borrow
    };

    task automatic chk(input string req, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic check_case(input int w, input int a, input int b, input bit sub,
                              input int gs, input int gx, input bit gso, input bit guo);
        int m, half, sa, sb, tv, beff, cin, cout, cmsb, eso, euo;
        string req_sum, req_so;
        m    = 1 << w;
        half = 1 << (w - 1);
        sa   = (a >= half) ? a - m : a;
        sb   = (b >= half) ? b - m : b;
        tv   = sub ? sa - sb : sa + sb;
        eso  = (tv > half - 1 || tv < -half) ? 1 : 0;
        euo  = sub ? ((a < b) ? 1 : 0) : ((a + b >= m) ? 1 : 0);
        beff = sub ? (m - 1 - b) : b;
        cin  = sub ? 1 : 0;
        cout = (a + beff + cin >= m) ? 1 : 0;
        cmsb = ((a % half) + (beff % half) + cin >= half) ? 1 : 0;
        req_sum = sub ? "R2" : "R1";
        req_so  = (sub && b == half) ? "R6" : "R3";
        chk(req_sum, "sum", gs, ((tv % m) + m) % m);
        chk("R4", "exact", gx, ((tv % (2 * m)) + 2 * m) % (2 * m));
        chk(req_so, "sovf", int'(gso), eso);
        chk("R3", "carry-method sovf", int'(gso), cout ^ cmsb);
        chk("R5", "uovf", int'(guo), euo);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        a8 = '0; b8 = '0; sub8 = 1'b0;
        a4 = '0; b4 = '0; sub4 = 1'b0;
        a3 = '0; b3 = '0; sub3 = 1'b0;
        ra = 4'h7; rb = 4'h7; rsub = 1'b0;

        // R8: reset state of the registered instance
        repeat (2) @(posedge clk);
        #1;
        chk("R8", "reset sum", int'(rs), 0);
        chk("R8", "reset exact", int'(rx), 0);
        chk("R8", "reset flags", int'({rso, ruo}), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: one-cycle latency, 5 + 3 at N=4
        @(negedge clk);
        ra = 4'h5; rb = 4'h3; rsub = 1'b0;
        @(posedge clk);
        #1;
        chk("R8", "latency sum", int'(rs), 8);
        chk("R8", "latency exact", int'(rx), 8);
        chk("R8", "latency sovf", int'(rso), 1);
        chk("R8", "latency uovf", int'(ruo), 0);
        @(negedge clk);
        ra = 4'h0; rb = 4'h1; rsub = 1'b1;
        #2;
        chk("R8", "hold before edge", int'(rs), 8);
        @(posedge clk);
        #1;
        chk("R8", "sub sum", int'(rs), 15);
        chk("R8", "sub exact", int'(rx), 31);
        chk("R8", "sub uovf", int'(ruo), 1);

        // Vector table at N=8
        foreach (VEC[i]) begin
            @(negedge clk);
            #1;
            a8 = VEC[i][27:20]; b8 = VEC[i][19:12]; sub8 = VEC[i][11];
            #1;
            chk("R4", "table exact", int'(x8), int'(VEC[i][10:2]));
            chk("R1", "table sum", int'(s8), int'(VEC[i][9:2]));
            chk("R3", "table sovf", int'(so8), int'(VEC[i][1]));
            chk("R5", "table uovf", int'(uo8), int'(VEC[i][0]));
        end

        // R7: hand-worked small cases
        @(negedge clk);
        #1;
        a3 = 3'b110; b3 = 3'b011; sub3 = 1'b0;
        #1;
        chk("R7", "3b add sum", int'(s3), 1);
        chk("R7", "3b add sovf", int'(so3), 0);
        #1;
        a3 = 3'b001; b3 = 3'b011; sub3 = 1'b1;
        #1;
        chk("R7", "3b sub sum", int'(s3), 6);
        chk("R7", "3b sub exact", int'(x3), 14);
        chk("R7", "3b sub sovf", int'(so3), 0);
        #1;
        a4 = 4'b1101; b4 = 4'b1010; sub4 = 1'b1;
        #1;
        chk("R7", "4b sub sum", int'(s4), 3);
        chk("R7", "4b sub sovf", int'(so4), 0);

        // Exhaustive N=4, both modes
        @(negedge clk);
        #1;
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    a4 = 4'(a); b4 = 4'(b); sub4 = s[0];
                    #1;
                    check_case(4, a, b, s[0], int'(s4), int'(x4), so4, uo4);
                    #1;
                end
            end
        end

        // Exhaustive N=8, both modes
        @(negedge clk);
        #1;
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    a8 = 8'(a); b8 = 8'(b); sub8 = s[0];
                    #1;
                    check_case(8, a, b, s[0], int'(s8), int'(x8), so8, uo8);
                    #1;
                end
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule